// File: doc/BRIEF.md
# PCI 64-bit Write Master with Width Fallback

This block is a PCI bus master for write bursts. It negotiates the width of the data phases for each transaction. When reset is released, it records whether its bus segment can carry 64-bit transfers. For each memory request on a 64-bit-capable bus, it asks for the wide path by driving REQ64# together with FRAME#. It reads the target's answer on ACK64# in the clock where DEVSEL# is first seen low. If the target accepts, every data phase carries one full 8-byte beat. If it does not, each beat is split into two 32-bit data phases. I/O requests, and all requests on a narrow bus, run as plain 32-bit cycles.

The local side presents one request at a time: a start address counted in 8-byte units, a memory or I/O flag, and a burst length in beats (at least 1). The current beat's data and byte enables are presented in show-ahead fashion. The block pulses `beat_pop` in the clock in which a beat is consumed, and the local side must then present the next beat. The bus side drives FRAME#, IRDY#, REQ64#, AD and C/BE#, and samples TRDY#, DEVSEL# and ACK64#. The target is assumed to claim every transaction and to complete it without retry or abort.

Top module: `pci_wide_master`

## Requirements
- R1: In the first clock after the internal reset is released, `bus_req64_n` is sampled. Low marks the bus as 64-bit capable. The recorded value then holds until the next reset, whatever the pin does afterwards.
- R2: REQ64# is driven low only for memory requests on a capable bus, and then falls and rises on exactly the same clocks as FRAME#. Otherwise it stays high.
- R3: The address phase is the clock in which FRAME# is low and IRDY# is high. In that clock, AD[31:0] carries the beat address shifted left by 3 with bits 2:0 zero. C/BE[3:0]# carries 4'b0111 for a memory write or 4'b0011 for an I/O write. AD[63:32] is driven to zero and C/BE[7:4]# to 4'b1111.
- R4: When ACK64# is low in the clock where DEVSEL# is first sampled low, each data phase moves one beat: AD[63:0] carries the beat data and C/BE[7:0]# carries the inverted byte enables.
- R5: Otherwise each beat takes two data phases. The first carries data bits 31:0 on AD[31:0] with C/BE[3:0]# set to the inverse of enables 3:0. The second carries data bits 63:32 on AD[31:0] with C/BE[3:0]# set to the inverse of enables 7:4.
- R6: FRAME# rises in the first clock of the final data phase once the width is known. It rises only while IRDY# is low. IRDY# stays low in every data clock until TRDY# completes the final phase.
- R7: If the only beat of a REQ64# burst completes in the same clock in which DEVSEL# is first sampled, one extra final data phase follows with all C/BE[7:0]# high.
- R8: While IRDY# is low and TRDY# is high, AD and C/BE# hold their values into the next clock.
- R9: Byte enables pass through unchanged in every data phase. A beat with no enables set gives all-high C/BE# lanes for its phases.
- R10: During reset, FRAME#, IRDY# and REQ64# are high and `req_ready` is low. `req_ready` is high only when idle after the capability has been recorded. `beat_pop` pulses exactly once per beat. The clock after a final data phase is idle, with FRAME# and IRDY# both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Local request present |
| req_ready | output | 1 | Master idle and able to accept a request |
| req_beat_addr | input | 29 | Start address in 8-byte units |
| req_mem | input | 1 | 1 = memory write, 0 = I/O write |
| req_beats | input | 8 | Burst length in 8-byte beats, at least 1 |
| wdata | input | 64 | Current beat data |
| wbe | input | 8 | Current beat byte enables, active high |
| beat_pop | output | 1 | Current beat consumed at this clock edge |
| bus_req64_n | input | 1 | REQ64# level sampled after reset |
| frame_n | output | 1 | FRAME# |
| irdy_n | output | 1 | IRDY# |
| req64_n | output | 1 | REQ64# |
| trdy_n | input | 1 | TRDY# |
| devsel_n | input | 1 | DEVSEL# |
| ack64_n | input | 1 | ACK64# |
| ad | output | 64 | Address/data lanes |
| cbe_n | output | 8 | Command and byte enable lanes |

## Verification
The bound checker examines the following on every clock: the capability bit holding after it is recorded, REQ64# never appearing without that bit or apart from FRAME#, the fixed upper lanes of the address phase, the FRAME#/IRDY# ordering, and lane stability in wait states. Only the bench scenarios can show that the width chosen from ACK64# matches the target's answer, and that the lane order of the fallback split is correct. They also show that the padding phase appears exactly when the burst ran out before the answer was known, and that byte totals and beat pops agree with the request. To do this, the bench runs a target model with varied DEVSEL# delays and TRDY# wait states against both wide and narrow targets, on capable and incapable buses.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } seq_state_e;

  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
  localparam logic [3:0] CMD_IO_WR  = 4'b0011;
endpackage

// File: rtl/pwm_reset_sync.sv
module pwm_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_s = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_cap_latch.sv
module pwm_cap_latch (
  input  logic clk,
  input  logic rst_s,
  input  logic bus_req64_n,
  output logic armed,
  output logic cap
);
  logic armed_q, cap_q;
  logic load_en;

  // capture once, on the first edge after the synchronized release
  assign load_en = !armed_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      armed_q <= 1'b0;
      cap_q   <= 1'b0;
    end else if (load_en) begin
      armed_q <= 1'b1;
      cap_q   <= !bus_req64_n;
    end
  end

  assign armed = armed_q;
  assign cap   = cap_q;
endmodule

// File: rtl/pwm_seq.sv
module pwm_seq
  import pwm_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_s,
  input  logic             armed,
  input  logic             cap,
  input  logic             req_valid,
  input  logic             req_mem,
  input  logic [LEN_W-1:0] req_beats,
  input  logic             devsel_n,
  input  logic             trdy_n,
  input  logic             ack64_n,
  output logic             req_ready,
  output logic             start,
  output logic             addr_ph,
  output logic             data_ph,
  output logic             half,
  output logic             pad,
  output logic             beat_pop,
  output logic             frame_n,
  output logic             irdy_n,
  output logic             req64_n
);
  seq_state_e       st_q, st_d;
  logic [LEN_W-1:0] beats_q, beats_d;
  logic             half_q, half_d;
  logic             dec_q, dec_d;
  logic             wide_q, wide_d;
  logic             wreq_q, wreq_d;
  logic             hit, wide_now, last, fin, reg_en;

  // outputs decoded from state
  always_comb begin
    req_ready = (st_q == ST_IDLE) && armed;
    start     = req_ready && req_valid;
    addr_ph   = (st_q == ST_ADDR);
    data_ph   = (st_q == ST_DATA);
    hit       = data_ph && !trdy_n;
    wide_now  = dec_q ? wide_q : (!devsel_n && !ack64_n);
    pad       = (beats_q == '0);
    last      = dec_q && (pad || ((beats_q == LEN_W'(1)) && (wide_q || half_q)));
    frame_n   = !(addr_ph || (data_ph && !last));
    irdy_n    = !data_ph;
    req64_n   = frame_n || !wreq_q;
    beat_pop  = hit && !pad && (wide_now || half_q);
    fin       = hit && last;
    half      = half_q;
  end

  // next state
  always_comb begin
    st_d    = st_q;
    beats_d = beats_q;
    half_d  = half_q;
    dec_d   = dec_q;
    wide_d  = wide_q;
    wreq_d  = wreq_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d    = ST_ADDR;
          beats_d = req_beats;
          half_d  = 1'b0;
          wreq_d  = cap && req_mem;
          dec_d   = !(cap && req_mem);
          wide_d  = 1'b0;
        end
      end
      ST_ADDR: st_d = ST_DATA;
      ST_DATA: begin
        if (!dec_q && !devsel_n) begin
          dec_d  = 1'b1;
          wide_d = !ack64_n;
        end
        if (fin) begin
          st_d = ST_IDLE;
        end else if (beat_pop) begin
          beats_d = beats_q - LEN_W'(1);
          half_d  = 1'b0;
        end else if (hit && !pad) begin
          half_d = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign reg_en = (st_q != ST_IDLE) || start;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q    <= ST_IDLE;
      beats_q <= '0;
      half_q  <= 1'b0;
      dec_q   <= 1'b0;
      wide_q  <= 1'b0;
      wreq_q  <= 1'b0;
    end else if (reg_en) begin
      st_q    <= st_d;
      beats_q <= beats_d;
      half_q  <= half_d;
      dec_q   <= dec_d;
      wide_q  <= wide_d;
      wreq_q  <= wreq_d;
    end
  end
endmodule

// File: rtl/pwm_lanes.sv
module pwm_lanes
  import pwm_pkg::*;
#(
  parameter  int LANES  = 8,
  localparam int DATA_W = 8 * LANES,
  localparam int HALF_W = DATA_W / 2,
  localparam int HB     = LANES / 2,
  localparam int AL     = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_s,
  input  logic              start,
  input  logic [HALF_W-AL-1:0] req_beat_addr,
  input  logic              req_mem,
  input  logic              addr_ph,
  input  logic              data_ph,
  input  logic              half,
  input  logic              pad,
  input  logic [DATA_W-1:0] wdata,
  input  logic [LANES-1:0]  wbe,
  output logic [DATA_W-1:0] ad,
  output logic [LANES-1:0]  cbe_n
);
  logic [HALF_W-AL-1:0] addr_q;
  logic [3:0]           cmd_q;
  logic [HALF_W-1:0]    hi_w, lo_w, lo_sel;
  logic [HB-1:0]        be_hi, be_lo, be_sel;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      addr_q <= '0;
      cmd_q  <= CMD_IO_WR;
    end else if (start) begin
      addr_q <= req_beat_addr;
      cmd_q  <= req_mem ? CMD_MEM_WR : CMD_IO_WR;
    end
  end

  assign hi_w   = wdata[DATA_W-1:HALF_W];
  assign lo_w   = wdata[HALF_W-1:0];
  assign be_hi  = wbe[LANES-1:HB];
  assign be_lo  = wbe[HB-1:0];
  // narrow second phase moves the upper dword onto the lower lanes
  assign lo_sel = half ? hi_w : lo_w;
  assign be_sel = half ? be_hi : be_lo;

  always_comb begin
    ad    = '0;
    cbe_n = '1;
    if (addr_ph) begin
      ad[HALF_W-1:0] = {addr_q, {AL{1'b0}}};
      cbe_n[3:0]     = cmd_q;
    end else if (data_ph) begin
      ad    = {hi_w, lo_sel};
      cbe_n = pad ? '1 : ~{be_hi, be_sel};
    end
  end
endmodule

// File: rtl/pci_wide_master.sv
module pci_wide_master
  import pwm_pkg::*;
#(
  parameter  int LANES  = 8,
  parameter  int LEN_W  = 8,
  localparam int DATA_W = 8 * LANES,
  localparam int HALF_W = DATA_W / 2,
  localparam int AL     = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [HALF_W-AL-1:0] req_beat_addr,
  input  logic                 req_mem,
  input  logic [LEN_W-1:0]     req_beats,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [LANES-1:0]     wbe,
  output logic                 beat_pop,
  input  logic                 bus_req64_n,
  output logic                 frame_n,
  output logic                 irdy_n,
  output logic                 req64_n,
  input  logic                 trdy_n,
  input  logic                 devsel_n,
  input  logic                 ack64_n,
  output logic [DATA_W-1:0]    ad,
  output logic [LANES-1:0]     cbe_n
);
  logic rst_s, armed_q, cap_q;
  logic start, addr_ph, data_ph, half, pad;

  pwm_reset_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_s (rst_s)
  );

  pwm_cap_latch u_cap (
    .clk         (clk),
    .rst_s       (rst_s),
    .bus_req64_n (bus_req64_n),
    .armed       (armed_q),
    .cap         (cap_q)
  );

  pwm_seq #(.LEN_W(LEN_W)) u_seq (
    .clk       (clk),
    .rst_s     (rst_s),
    .armed     (armed_q),
    .cap       (cap_q),
    .req_valid (req_valid),
    .req_mem   (req_mem),
    .req_beats (req_beats),
    .devsel_n  (devsel_n),
    .trdy_n    (trdy_n),
    .ack64_n   (ack64_n),
    .req_ready (req_ready),
    .start     (start),
    .addr_ph   (addr_ph),
    .data_ph   (data_ph),
    .half      (half),
    .pad       (pad),
    .beat_pop  (beat_pop),
    .frame_n   (frame_n),
    .irdy_n    (irdy_n),
    .req64_n   (req64_n)
  );

  pwm_lanes #(.LANES(LANES)) u_lanes (
    .clk           (clk),
    .rst_s         (rst_s),
    .start         (start),
    .req_beat_addr (req_beat_addr),
    .req_mem       (req_mem),
    .addr_ph       (addr_ph),
    .data_ph       (data_ph),
    .half          (half),
    .pad           (pad),
    .wdata         (wdata),
    .wbe           (wbe),
    .ad            (ad),
    .cbe_n         (cbe_n)
  );
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter  int LANES  = 8,
  localparam int DATA_W = 8 * LANES,
  localparam int HALF_W = DATA_W / 2
) (
  input logic              clk,
  input logic              rst_s,
  input logic              armed_q,
  input logic              cap_q,
  input logic              frame_n,
  input logic              irdy_n,
  input logic              trdy_n,
  input logic              req64_n,
  input logic [DATA_W-1:0] ad,
  input logic [LANES-1:0]  cbe_n
);
  assert_cap_hold_R1: assert property (@(posedge clk) disable iff (!rst_s)
    (armed_q && $past(armed_q)) |-> $stable(cap_q));

  assert_req64_needs_cap_R2: assert property (@(posedge clk) disable iff (!rst_s)
    !req64_n |-> cap_q);

  assert_req64_within_frame_R2: assert property (@(posedge clk) disable iff (!rst_s)
    frame_n |-> req64_n);

  assert_addr_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (!frame_n && irdy_n) |-> ((ad[DATA_W-1:HALF_W] == '0) && (cbe_n[LANES-1:LANES/2] == '1)));

  assert_frame_rise_with_irdy_R6: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(frame_n) |-> !irdy_n);

  assert_irdy_hold_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (!irdy_n && trdy_n) |=> !irdy_n);

  assert_stall_stable_R8: assert property (@(posedge clk) disable iff (!rst_s)
    (!irdy_n && trdy_n) |=> ($stable(ad) && $stable(cbe_n)));
endmodule

bind pci_wide_master pwm_checker #(.LANES(LANES)) u_chk (
  .clk     (clk),
  .rst_s   (rst_s),
  .armed_q (armed_q),
  .cap_q   (cap_q),
  .frame_n (frame_n),
  .irdy_n  (irdy_n),
  .trdy_n  (trdy_n),
  .req64_n (req64_n),
  .ad      (ad),
  .cbe_n   (cbe_n)
);

// File: tb/pci_wide_master_test.sv
`timescale 1ns/1ps
module pci_wide_master_test;
  localparam int LANES = 8;
  localparam int LEN_W = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [28:0] req_beat_addr = '0;
  logic        req_mem = 1'b0;
  logic [7:0]  req_beats = 8'd1;
  logic [63:0] wdata;
  logic [7:0]  wbe;
  logic        beat_pop;
  logic        bus_req64_n = 1'b1;
  logic        frame_n, irdy_n, req64_n;
  logic        trdy_n = 1'b1, devsel_n = 1'b1, ack64_n = 1'b1;
  logic [63:0] ad;
  logic [7:0]  cbe_n;

  always #4 clk = ~clk;

  pci_wide_master #(.LANES(LANES), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_beat_addr(req_beat_addr), .req_mem(req_mem), .req_beats(req_beats),
    .wdata(wdata), .wbe(wbe), .beat_pop(beat_pop), .bus_req64_n(bus_req64_n),
    .frame_n(frame_n), .irdy_n(irdy_n), .req64_n(req64_n), .trdy_n(trdy_n),
    .devsel_n(devsel_n), .ack64_n(ack64_n), .ad(ad), .cbe_n(cbe_n)
  );

  typedef struct {
    logic [63:0] ad;
    logic [7:0]  cbe;
    bit          full;
    bit          cmp_ad;
    bit          last;
    string       tag;
  } phase_t;

  phase_t expq[$];
  int total = 0;
  int fails = 0;

  // local data source: show-ahead beats indexed by pops since request
  logic [63:0] beat_data [0:15];
  logic [7:0]  beat_be   [0:15];
  int pop_cnt = 0;
  int base_cnt = 0;
  logic [3:0] cur_i;
  assign cur_i = 4'(pop_cnt - base_cnt);
  assign wdata = beat_data[cur_i];
  assign wbe   = beat_be[cur_i];
  always @(posedge clk) if (beat_pop) pop_cnt <= pop_cnt + 1;

  // reference state
  bit          cap_exp = 1'b0;
  bit          cur_wreq = 1'b0;
  logic [31:0] exp_addr = '0;
  logic [3:0]  exp_cmd = '0;
  bit          tgt_wide = 1'b0;
  int          dev_dly = 0, tw = 0;
  bit          active = 1'b0, req64_seen = 1'b0, post_final = 1'b0, stall_prev = 1'b0;
  int          dclk = 0, wcnt = 0, bytes_obs = 0;
  logic [63:0] st_ad = '0;
  logic [7:0]  st_cbe = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // target model, driven and sampled at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      devsel_n = 1'b1; trdy_n = 1'b1; ack64_n = 1'b1;
      active = 1'b0; post_final = 1'b0; stall_prev = 1'b0;
    end else begin
      chk(req64_n == (frame_n | !cur_wreq), "R2 REQ64# tracks FRAME#",
          64'(req64_n), 64'(frame_n | !cur_wreq));
      if (post_final) begin
        chk(frame_n && irdy_n, "R10 idle clock after final phase", 64'({frame_n, irdy_n}), 64'd3);
        post_final = 1'b0;
      end
      if (!active) begin
        devsel_n = 1'b1; trdy_n = 1'b1; ack64_n = 1'b1;
        if (!frame_n && irdy_n) begin
          chk(ad[31:0] == exp_addr, "R3 address lanes", 64'(ad[31:0]), 64'(exp_addr));
          chk(cbe_n[3:0] == exp_cmd, "R3 command", 64'(cbe_n[3:0]), 64'(exp_cmd));
          chk(ad[63:32] == 32'h0 && cbe_n[7:4] == 4'hF, "R3 upper lanes in address phase",
              {ad[63:32], 24'h0, cbe_n}, 64'h0000_0000_0000_00F0);
          chk(req64_n == !cur_wreq, "R1 R2 REQ64# in address phase", 64'(req64_n), 64'(!cur_wreq));
          req64_seen = !req64_n;
          active = 1'b1; dclk = 0; wcnt = 0; stall_prev = 1'b0;
        end
      end else begin
        chk(!irdy_n, "R6 IRDY# low in data clock", 64'(irdy_n), 64'd0);
        if (stall_prev)
          chk(ad == st_ad && cbe_n == st_cbe, "R8 lanes stable in wait state", ad ^ st_ad, 64'd0);
        if (dclk >= dev_dly) begin
          devsel_n = 1'b0;
          ack64_n  = !(tgt_wide && req64_seen);
          trdy_n   = !(wcnt >= tw);
          wcnt++;
        end else begin
          devsel_n = 1'b1; ack64_n = 1'b1; trdy_n = 1'b1;
        end
        if (!trdy_n) begin
          if (expq.size() == 0) begin
            chk(1'b0, "R4 R5 unexpected data phase", 64'(cbe_n), 64'd0);
          end else begin
            phase_t e;
            e = expq.pop_front();
            chk(frame_n == e.last, {e.tag, " R6 FRAME# marks final phase"}, 64'(frame_n), 64'(e.last));
            if (e.full) begin
              if (e.cmp_ad) chk(ad == e.ad, {e.tag, " data lanes"}, ad, e.ad);
              chk(cbe_n == e.cbe, {e.tag, " R9 byte enables"}, 64'(cbe_n), 64'(e.cbe));
              bytes_obs += $countones(~cbe_n);
            end else begin
              chk(ad[31:0] == e.ad[31:0], {e.tag, " low data lanes"}, 64'(ad[31:0]), 64'(e.ad[31:0]));
              chk(cbe_n[3:0] == e.cbe[3:0], {e.tag, " R9 low byte enables"}, 64'(cbe_n[3:0]), 64'(e.cbe[3:0]));
              bytes_obs += $countones(~cbe_n[3:0]);
            end
          end
          wcnt = 0;
          stall_prev = 1'b0;
          if (frame_n) begin
            active = 1'b0;
            post_final = 1'b1;
          end
        end else begin
          stall_prev = 1'b1;
          st_ad = ad;
          st_cbe = cbe_n;
        end
        dclk++;
      end
    end
  end

  task automatic do_reset(input bit capable);
    rst_n = 1'b0;
    bus_req64_n = !capable;
    cap_exp = capable;
    cur_wreq = 1'b0;
    repeat (3) @(negedge clk);
    chk(frame_n && irdy_n && req64_n, "R10 bus idle in reset", 64'({frame_n, irdy_n, req64_n}), 64'd7);
    chk(!req_ready, "R10 not ready in reset", 64'(req_ready), 64'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    bus_req64_n = capable;  // pin flips after capture; recorded value must hold (R1)
    chk(req_ready, "R10 ready after capability recorded", 64'(req_ready), 64'd1);
  endtask

  task automatic run_txn(input bit mem, input logic [28:0] baddr, input int n,
                         input bit twide, input int ddly, input int twait, input bit be_mode);
    bit wreq, wide;
    int exp_bytes;
    wreq = cap_exp && mem;
    wide = wreq && twide;
    exp_bytes = 0;
    base_cnt = pop_cnt;
    for (int i = 0; i < n; i++) begin
      phase_t p;
      logic [7:0] b;
      beat_data[4'(i)] = {32'hC0DE_0000 + 32'(i * 17 + n), 32'h1234_5600 + 32'(i)};
      case (i % 4)
        0: b = be_mode ? 8'h00 : 8'hFF;
        1: b = be_mode ? 8'h0F : 8'hFF;
        2: b = be_mode ? 8'hF0 : 8'hFF;
        default: b = be_mode ? 8'h5A : 8'hFF;
      endcase
      beat_be[4'(i)] = b;
      exp_bytes += $countones(b);
      if (wide) begin
        p = '{ad: beat_data[4'(i)], cbe: ~b, full: 1'b1, cmp_ad: 1'b1, last: 1'b0, tag: "R4"};
        expq.push_back(p);
      end else begin
        p = '{ad: {32'h0, beat_data[4'(i)][31:0]}, cbe: {4'hF, ~b[3:0]}, full: 1'b0, cmp_ad: 1'b1, last: 1'b0, tag: "R5"};
        expq.push_back(p);
        p = '{ad: {32'h0, beat_data[4'(i)][63:32]}, cbe: {4'hF, ~b[7:4]}, full: 1'b0, cmp_ad: 1'b1, last: 1'b0, tag: "R5"};
        expq.push_back(p);
      end
    end
    if (wide && twait == 0 && n == 1) begin
      phase_t p;
      p = '{ad: 64'h0, cbe: 8'hFF, full: 1'b1, cmp_ad: 1'b0, last: 1'b0, tag: "R7"};
      expq.push_back(p);
    end
    expq[expq.size() - 1].last = 1'b1;
    cur_wreq = wreq;
    tgt_wide = twide; dev_dly = ddly; tw = twait;
    exp_addr = {baddr, 3'b000};
    exp_cmd  = mem ? 4'b0111 : 4'b0011;
    bytes_obs = 0;
    req_beat_addr = baddr;
    req_mem = mem;
    req_beats = 8'(n);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (expq.size() != 0 || active) @(negedge clk);
    @(negedge clk);
    chk(bytes_obs == exp_bytes, wide ? "R4 byte count" : "R5 byte count", 64'(bytes_obs), 64'(exp_bytes));
    chk(pop_cnt - base_cnt == n, "R10 one pop per beat", 64'(pop_cnt - base_cnt), 64'(n));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    run_txn(1'b1, 29'h0000100, 4, 1'b1, 0, 0, 1'b0);  // R4 wide burst, fast target
    run_txn(1'b1, 29'h0000200, 1, 1'b1, 0, 0, 1'b0);  // R7 single beat completes before width known
    run_txn(1'b1, 29'h0000300, 3, 1'b0, 1, 1, 1'b1);  // R5 R9 narrow fallback, slow target, sparse enables
    run_txn(1'b1, 29'h0000400, 1, 1'b1, 2, 1, 1'b1);  // R4 R8 single beat, width known early
    run_txn(1'b0, 29'h0000500, 2, 1'b1, 0, 0, 1'b1);  // R2 I/O request never asks for 64 bits
    run_txn(1'b1, 29'h0000600, 1, 1'b0, 0, 0, 1'b1);  // R5 narrow single beat, fast target
    run_txn(1'b1, 29'h0000700, 4, 1'b1, 1, 2, 1'b1);  // R4 R8 wide with wait states
    do_reset(1'b0);
    run_txn(1'b1, 29'h0000800, 2, 1'b1, 0, 0, 1'b0);  // R1 incapable bus stays 32-bit
    run_txn(1'b1, 29'h0000900, 3, 1'b1, 1, 1, 1'b1);  // R1 R5
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule